// File: doc/BRIEF.md
# Cycle-Stealing Bus Cycle Sequencer

This block sequences the machine cycles of a small 8-bit processor core. Each machine cycle is eight clocks long. It sends a 16-bit memory address over an 8-bit bus in two halves, upper byte first. A strobe tells external logic when to capture the upper half, and a second strobe near the end of the cycle marks the moment data and I/O move. The sequencer alternates instruction fetch and execute cycles. When a direct-memory-access request is pending at the end of an execute cycle, it slips extra DMA cycles in before the next fetch. Those cycles take their address from the DMA pointer register, and the sequencer signals the register file to advance that pointer by one after each transfer. A pending interrupt gets one interrupt cycle before the next fetch.

The core supplies the fetch address, the execute-cycle operand address and its direction, and the current DMA pointer value. The register storage and instruction decoding live elsewhere. A two-bit state code tells the outside world what kind of cycle is on the bus. Two mode inputs select run, pause, reset, or load. In load mode an external agent fills memory through DMA-in cycles while no instruction is ever fetched. All ports are plain level signals. There is no stream handshake, because the bus timing is fixed by the cycle counter and cannot be back-pressured; the pause mode is the only way to stall it.

Top module: `cyc_steal_seq`

## Requirements
- R1: After `rst_ni` is low, and whenever no cycle is in progress, `act_o` is 0. In that state `mrd_o`, `mwr_o`, `tpa_o`, `tpb_o` and `r0_inc_o` are 0, and `abus_o` and `sc_o` are 0.
- R2: A machine cycle occupies 8 clocks, numbered 0 to 7. `tpa_o` is high only in clock 1 and `tpb_o` only in clock 7, one clock each while not paused.
- R3: `abus_o` carries the upper address byte in clocks 0 and 1 and the lower byte in clocks 2 to 7.
- R4: In run mode a fetch cycle, addressed by `pc_i`, is always followed by an execute cycle addressed by `ea_i`. The state code `sc_o` is 00 for fetch, 01 for execute, 10 for DMA and 11 for interrupt. Address and direction are captured at the clock edge that starts the cycle.
- R5: `mrd_o` is high in clocks 2 to 7 of fetch cycles, of DMA-out cycles, and of execute cycles with `ex_rd_i`. `mwr_o` is high in clocks 5 to 7 of DMA-in cycles and of execute cycles with `ex_wr_i` (and not `ex_rd_i`). The two are never high together.
- R6: At the end of an execute or DMA cycle, a pending DMA request starts a DMA cycle addressed by `r0_i`. A request that arrives at the end of a fetch waits until after the execute cycle.
- R7: When `dma_in_i` and `dma_out_i` are both pending, a DMA-in cycle is chosen.
- R8: `r0_inc_o` is high for exactly clock 7 of every DMA cycle and at no other time.
- R9: With `irq_i` high and no DMA request at the end of an execute or DMA cycle, an interrupt cycle follows. It drives no memory strobe and is always followed by a fetch.
- R10: With `clear_i`=1 and `hold_i`=0 (reset mode), the cycle in progress is abandoned at the next clock edge and the block stays idle. On return to run mode, a fetch starts at the next clock edge.
- R11: With `hold_i`=1 and `clear_i`=0 (pause mode), every output holds its value. On release the cycle resumes from the clock where it stopped.
- R12: With `hold_i`=1 and `clear_i`=1 (load mode), the only new cycles are DMA-in cycles, started while `dma_in_i` is high. Otherwise the block stays idle, and `dma_out_i` and `irq_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Mode select bit (pause / load) |
| clear_i | input | 1 | Mode select bit (reset / load) |
| pc_i | input | 16 | Program counter value for fetch cycles |
| ea_i | input | 16 | Operand address for execute cycles |
| ex_rd_i | input | 1 | Execute cycle reads memory |
| ex_wr_i | input | 1 | Execute cycle writes memory |
| r0_i | input | 16 | DMA pointer value |
| dma_in_i | input | 1 | DMA-in request (memory write) |
| dma_out_i | input | 1 | DMA-out request (memory read) |
| irq_i | input | 1 | Interrupt request |
| abus_o | output | 8 | Multiplexed address byte |
| tpa_o | output | 1 | Upper-address latch strobe |
| tpb_o | output | 1 | Data / I/O transfer strobe |
| mrd_o | output | 1 | Memory read enable |
| mwr_o | output | 1 | Memory write enable |
| sc_o | output | 2 | Cycle type state code |
| act_o | output | 1 | A machine cycle is in progress |
| r0_inc_o | output | 1 | Advance the DMA pointer by one |

## Verification
A wrong phase count moves `tpa_o` or `tpb_o` off clocks 1 and 7, or switches the address byte at the wrong clock, and this is visible within the first cycle. A wrong latched cycle kind or wrong next-cycle choice shows on `sc_o`, on the address byte and on the read/write strobes from clock 0 of the affected cycle. An ordering fault, such as a missed DMA priority or a fetch in load mode, therefore appears one cycle boundary after the inputs that should have selected otherwise. Freeze and abandon faults of the mode logic show on the very next clock edge.

// File: rtl/css_pkg.sv
package css_pkg;

  typedef enum logic [2:0] {
    CK_FETCH,
    CK_EXEC,
    CK_DMA_IN,
    CK_DMA_OUT,
    CK_INTR
  } cyc_kind_e;

  localparam logic [1:0] SC_FETCH = 2'b00;
  localparam logic [1:0] SC_EXEC  = 2'b01;
  localparam logic [1:0] SC_DMA   = 2'b10;
  localparam logic [1:0] SC_INTR  = 2'b11;

  function automatic logic [1:0] sc_code(cyc_kind_e k);
    case (k)
      CK_FETCH:   return SC_FETCH;
      CK_EXEC:    return SC_EXEC;
      CK_DMA_IN,
      CK_DMA_OUT: return SC_DMA;
      default:    return SC_INTR;
    endcase
  endfunction

  function automatic logic is_dma(cyc_kind_e k);
    return (k == CK_DMA_IN) || (k == CK_DMA_OUT);
  endfunction

endpackage

// File: rtl/css_phase_ctr.sv
module css_phase_ctr #(
  parameter int CYC_LEN = 8,
  parameter int PHW     = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           inc_i,
  output logic [PHW-1:0] phase_o,
  output logic           last_o
);
  localparam logic [PHW-1:0] PH_LAST = PHW'(CYC_LEN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_o <= '0;
    else if (clr_i) phase_o <= '0;
    else if (inc_i) phase_o <= phase_o + 1'b1;
  end

  assign last_o = (phase_o == PH_LAST);
endmodule

// File: rtl/css_next_pick.sv
module css_next_pick
  import css_pkg::*;
(
  input  logic      act_i,
  input  cyc_kind_e kind_i,
  input  logic      load_md_i,
  input  logic      dma_in_i,
  input  logic      dma_out_i,
  input  logic      irq_i,
  output logic      nxt_vld_o,
  output cyc_kind_e nxt_kind_o
);
  always_comb begin
    nxt_vld_o  = 1'b1;
    nxt_kind_o = CK_FETCH;
    if (load_md_i) begin
      nxt_vld_o  = dma_in_i;
      nxt_kind_o = CK_DMA_IN;
    end else if (act_i) begin
      case (kind_i)
        CK_FETCH: nxt_kind_o = CK_EXEC;
        CK_INTR:  nxt_kind_o = CK_FETCH;
        default: begin
          if (dma_in_i)       nxt_kind_o = CK_DMA_IN;
          else if (dma_out_i) nxt_kind_o = CK_DMA_OUT;
          else if (irq_i)     nxt_kind_o = CK_INTR;
          else                nxt_kind_o = CK_FETCH;
        end
      endcase
    end
  end
endmodule

// File: rtl/css_bus_drv.sv
module css_bus_drv
  import css_pkg::*;
#(
  parameter int BW     = 8,
  parameter int PHW    = 3,
  parameter int TPA_PH = 1,
  parameter int TPB_PH = 7,
  parameter int RD_ST  = 2,
  parameter int WR_ST  = 5
) (
  input  logic            act_i,
  input  cyc_kind_e       kind_i,
  input  logic [PHW-1:0]  phase_i,
  input  logic [2*BW-1:0] addr_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic            step_i,
  output logic [BW-1:0]   abus_o,
  output logic            tpa_o,
  output logic            tpb_o,
  output logic            mrd_o,
  output logic            mwr_o,
  output logic [1:0]      sc_o,
  output logic            r0_inc_o
);
  localparam logic [PHW-1:0] PH_A = PHW'(TPA_PH);
  localparam logic [PHW-1:0] PH_B = PHW'(TPB_PH);
  localparam logic [PHW-1:0] PH_R = PHW'(RD_ST);
  localparam logic [PHW-1:0] PH_W = PHW'(WR_ST);

  logic upper_half;
  assign upper_half = (phase_i <= PH_A);

  always_comb begin
    abus_o = '0;
    if (act_i) abus_o = upper_half ? addr_i[2*BW-1:BW] : addr_i[BW-1:0];
  end

  assign tpa_o    = act_i && (phase_i == PH_A);
  assign tpb_o    = act_i && (phase_i == PH_B);
  assign mrd_o    = act_i && rd_i && (phase_i >= PH_R);
  assign mwr_o    = act_i && wr_i && (phase_i >= PH_W);
  assign sc_o     = act_i ? sc_code(kind_i) : 2'b00;
  assign r0_inc_o = tpb_o && is_dma(kind_i) && step_i;
endmodule

// File: rtl/cyc_steal_seq.sv
module cyc_steal_seq
  import css_pkg::*;
#(
  parameter int BW      = 8,
  parameter int CYC_LEN = 8,
  parameter int TPA_PH  = 1,
  parameter int TPB_PH  = 7,
  parameter int RD_ST   = 2,
  parameter int WR_ST   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  logic            clear_i,
  input  logic [2*BW-1:0] pc_i,
  input  logic [2*BW-1:0] ea_i,
  input  logic            ex_rd_i,
  input  logic            ex_wr_i,
  input  logic [2*BW-1:0] r0_i,
  input  logic            dma_in_i,
  input  logic            dma_out_i,
  input  logic            irq_i,
  output logic [BW-1:0]   abus_o,
  output logic            tpa_o,
  output logic            tpb_o,
  output logic            mrd_o,
  output logic            mwr_o,
  output logic [1:0]      sc_o,
  output logic            act_o,
  output logic            r0_inc_o
);
  localparam int AW  = 2 * BW;
  localparam int PHW = $clog2(CYC_LEN);

  // mode decode
  logic md_pause, md_reset, md_load, step;
  assign md_pause = hold_i && !clear_i;
  assign md_reset = clear_i && !hold_i;
  assign md_load  = hold_i && clear_i;
  assign step     = !md_pause && !md_reset;

  // cycle context
  logic            act_q, rd_q, wr_q;
  cyc_kind_e       kind_q;
  logic [AW-1:0]   addr_q;
  logic [PHW-1:0]  phase;
  logic            last, boundary;
  logic            nxt_vld, nxt_rd, nxt_wr;
  cyc_kind_e       nxt_kind;
  logic [AW-1:0]   nxt_addr;

  assign boundary = !act_q || last;

  css_phase_ctr #(.CYC_LEN(CYC_LEN), .PHW(PHW)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (md_reset || (step && boundary)),
    .inc_i   (step && act_q && !last),
    .phase_o (phase),
    .last_o  (last)
  );

  css_next_pick u_pick (
    .act_i      (act_q),
    .kind_i     (kind_q),
    .load_md_i  (md_load),
    .dma_in_i   (dma_in_i),
    .dma_out_i  (dma_out_i),
    .irq_i      (irq_i),
    .nxt_vld_o  (nxt_vld),
    .nxt_kind_o (nxt_kind)
  );

  always_comb begin
    nxt_addr = pc_i;
    nxt_rd   = 1'b0;
    nxt_wr   = 1'b0;
    case (nxt_kind)
      CK_FETCH: nxt_rd = 1'b1;
      CK_EXEC: begin
        nxt_addr = ea_i;
        nxt_rd   = ex_rd_i;
        nxt_wr   = ex_wr_i && !ex_rd_i;
      end
      CK_DMA_IN: begin
        nxt_addr = r0_i;
        nxt_wr   = 1'b1;
      end
      CK_DMA_OUT: begin
        nxt_addr = r0_i;
        nxt_rd   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      kind_q <= CK_FETCH;
      addr_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else if (md_reset) begin
      act_q <= 1'b0;
    end else if (step && boundary) begin
      act_q <= nxt_vld;
      if (nxt_vld) begin
        kind_q <= nxt_kind;
        addr_q <= nxt_addr;
        rd_q   <= nxt_rd;
        wr_q   <= nxt_wr;
      end
    end
  end

  css_bus_drv #(
    .BW(BW), .PHW(PHW), .TPA_PH(TPA_PH), .TPB_PH(TPB_PH),
    .RD_ST(RD_ST), .WR_ST(WR_ST)
  ) u_drv (
    .act_i    (act_q),
    .kind_i   (kind_q),
    .phase_i  (phase),
    .addr_i   (addr_q),
    .rd_i     (rd_q),
    .wr_i     (wr_q),
    .step_i   (step),
    .abus_o   (abus_o),
    .tpa_o    (tpa_o),
    .tpb_o    (tpb_o),
    .mrd_o    (mrd_o),
    .mwr_o    (mwr_o),
    .sc_o     (sc_o),
    .r0_inc_o (r0_inc_o)
  );

  assign act_o = act_q;
endmodule

// File: rtl/cyc_steal_seq_chk.sv
module cyc_steal_seq_chk #(
  parameter int BW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hold_i,
  input logic          clear_i,
  input logic [BW-1:0] abus_o,
  input logic          tpa_o,
  input logic          tpb_o,
  input logic          mrd_o,
  input logic          mwr_o,
  input logic [1:0]    sc_o,
  input logic          act_o,
  input logic          r0_inc_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tpa_o && tpb_o)); // R2

  AST_TPA_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tpa_o && !(hold_i && !clear_i)) |=> !tpa_o); // R2

  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mrd_o && mwr_o)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_o |-> (!mrd_o && !mwr_o && !tpa_o && !tpb_o && !r0_inc_o
                && sc_o == 2'b00 && abus_o == '0)); // R1

  AST_R0INC_AT_TPB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r0_inc_o |-> (tpb_o && sc_o == 2'b10)); // R8

  AST_CLEAR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !hold_i) |=> !act_o); // R10

  AST_PAUSE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clear_i) |=> ($stable(abus_o) && $stable(sc_o) && $stable(mrd_o)
                              && $stable(mwr_o) && $stable(act_o) && $stable(tpb_o))); // R11

  AST_LOAD_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(act_o) && $past(hold_i && clear_i)) |-> sc_o == 2'b10); // R12
endmodule

bind cyc_steal_seq cyc_steal_seq_chk #(.BW(BW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hold_i   (hold_i),
  .clear_i  (clear_i),
  .abus_o   (abus_o),
  .tpa_o    (tpa_o),
  .tpb_o    (tpb_o),
  .mrd_o    (mrd_o),
  .mwr_o    (mwr_o),
  .sc_o     (sc_o),
  .act_o    (act_o),
  .r0_inc_o (r0_inc_o)
);

// File: tb/sim_cyc_steal_seq.sv
module sim_cyc_steal_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hold_i = 1'b0, clear_i = 1'b0;
  logic [15:0] pc_i = '0, ea_i = '0, r0_i = '0;
  logic        ex_rd_i = 1'b0, ex_wr_i = 1'b0;
  logic        dma_in_i = 1'b0, dma_out_i = 1'b0, irq_i = 1'b0;
  logic [7:0]  abus_o;
  logic        tpa_o, tpb_o, mrd_o, mwr_o, act_o, r0_inc_o;
  logic [1:0]  sc_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cyc_steal_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .hold_i(hold_i), .clear_i(clear_i),
    .pc_i(pc_i), .ea_i(ea_i), .ex_rd_i(ex_rd_i), .ex_wr_i(ex_wr_i),
    .r0_i(r0_i), .dma_in_i(dma_in_i), .dma_out_i(dma_out_i), .irq_i(irq_i),
    .abus_o(abus_o), .tpa_o(tpa_o), .tpb_o(tpb_o), .mrd_o(mrd_o),
    .mwr_o(mwr_o), .sc_o(sc_o), .act_o(act_o), .r0_inc_o(r0_inc_o)
  );

  typedef struct packed {
    logic dmi, dmo, irq, exr, exw;
    logic [1:0] sc;
    logic rd, wr;
    logic [1:0] asel; // 0 pc, 1 ea, 2 r0
  } vec_t;

  // inputs applied before a cycle boundary, expected kind of the cycle that follows
  localparam vec_t TBL [15] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'b00, 1'b1,1'b0, 2'd0},  // R4 fetch from idle
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 2'b01, 1'b1,1'b0, 2'd1},  // R4 execute read
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 2'b10, 1'b0,1'b1, 2'd2},  // R6 DMA-in after execute
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 2'b10, 1'b0,1'b1, 2'd2},  // R7 both pending, DMA-in wins
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 2'b10, 1'b1,1'b0, 2'd2},  // R6 DMA-out continues
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'b00, 1'b1,1'b0, 2'd0},  // R4 fetch after DMA
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 2'b01, 1'b0,1'b1, 2'd1},  // R5 execute write
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 2'b11, 1'b0,1'b0, 2'd0},  // R9 interrupt cycle
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 2'b00, 1'b1,1'b0, 2'd0},  // R9 fetch after interrupt
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'b01, 1'b0,1'b0, 2'd1},  // R5 execute without memory
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 2'b10, 1'b1,1'b0, 2'd2},  // R9 DMA-out before interrupt
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 2'b11, 1'b0,1'b0, 2'd0},  // R9 interrupt after DMA
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'b00, 1'b1,1'b0, 2'd0},  // R4
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 2'b01, 1'b0,1'b0, 2'd1},  // R6 request after fetch waits
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 2'b00, 1'b1,1'b0, 2'd0}   // R4
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  vec_t        v;
  logic [15:0] xa;
  logic        is_dma;

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "act", act_o, 0);
    chk("R1", "abus", abus_o, 0);
    chk("R1", "sc", sc_o, 0);
    chk("R1", "strobes", {tpa_o, tpb_o, mrd_o, mwr_o, r0_inc_o}, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < 15; i++) begin
      v = TBL[i];
      dma_in_i = v.dmi; dma_out_i = v.dmo; irq_i = v.irq;
      ex_rd_i = v.exr; ex_wr_i = v.exw;
      pc_i = 16'h10A0 + 16'(i);
      ea_i = 16'h2BB0 + 16'(i);
      r0_i = 16'h3CC0 + 16'(i);
      xa = (v.asel == 2'd1) ? ea_i : (v.asel == 2'd2) ? r0_i : pc_i;
      is_dma = (v.sc == 2'b10);
      for (int p = 0; p < 8; p++) begin
        tick();
        chk("R4", "act", act_o, 1);
        chk("R4", "sc", sc_o, v.sc);
        chk("R2", "tpa", tpa_o, p == 1);
        chk("R2", "tpb", tpb_o, p == 7);
        chk("R3", "abus", abus_o, (p <= 1) ? xa[15:8] : xa[7:0]);
        chk("R5", "mrd", mrd_o, v.rd && p >= 2);
        chk("R5", "mwr", mwr_o, v.wr && p >= 5);
        chk("R8", "r0_inc", r0_inc_o, is_dma && p == 7);
      end
    end

    // R11 pause in the middle of an execute read
    dma_in_i = 0; dma_out_i = 0; irq_i = 0;
    ex_rd_i = 1; ex_wr_i = 0; ea_i = 16'hC3D4;
    repeat (4) tick();
    chk("R11", "abus before pause", abus_o, 8'hD4);
    hold_i = 1'b1;
    ea_i = 16'h0000; ex_rd_i = 0;
    repeat (5) begin
      tick();
      chk("R11", "sc frozen", sc_o, 2'b01);
      chk("R11", "abus frozen", abus_o, 8'hD4);
      chk("R11", "mrd frozen", mrd_o, 1);
      chk("R11", "tpb frozen", tpb_o, 0);
    end
    hold_i = 1'b0;
    repeat (3) tick();
    chk("R11", "tpb not yet", tpb_o, 0);
    tick();
    chk("R11", "tpb after resume", tpb_o, 1);

    // R10 reset mode abandons and stays idle despite requests
    clear_i = 1'b1; dma_in_i = 1'b1; irq_i = 1'b1;
    repeat (3) begin
      tick();
      chk("R10", "act", act_o, 0);
      chk("R10", "mrd/mwr", {mrd_o, mwr_o}, 0);
      chk("R10", "r0_inc", r0_inc_o, 0);
    end

    // R12 load mode: no fetch, dma_out and irq ignored
    hold_i = 1'b1; dma_in_i = 1'b0; dma_out_i = 1'b1;
    repeat (10) tick();
    chk("R12", "idle without dma_in", act_o, 0);
    dma_in_i = 1'b1; r0_i = 16'hBEEF;
    tick();
    chk("R12", "dma-in starts", act_o, 1);
    chk("R12", "sc dma", sc_o, 2'b10);
    chk("R12", "abus upper", abus_o, 8'hBE);
    repeat (2) tick();
    chk("R12", "abus lower", abus_o, 8'hEF);
    repeat (3) tick();
    chk("R12", "mwr", mwr_o, 1);
    chk("R12", "mrd", mrd_o, 0);
    repeat (2) tick();
    chk("R8", "r0_inc in load", r0_inc_o, 1);
    dma_in_i = 1'b0;
    tick();
    chk("R12", "idle after dma, no fetch", act_o, 0);

    // R10 leaving to run mode fetches at once
    hold_i = 1'b0; clear_i = 1'b0; dma_out_i = 1'b0; irq_i = 1'b0;
    pc_i = 16'h7788;
    tick();
    chk("R10", "fetch after release", sc_o, 2'b00);
    chk("R10", "act after release", act_o, 1);
    chk("R10", "fetch address", abus_o, 8'h77);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule